// File: doc/BRIEF.md
# Bottleneck Dispatch Table

This block sits beside one small core and decides where each annotated bottleneck call runs. It holds a small associative table that pairs a bottleneck identifier with the large core chosen to accelerate it. When the core issues a bottleneck call, the identifier is looked up. If the identifier is present, the block forms a remote request that carries the identifier, the target program counter, the stack pointer and this core's own number, addressed to the recorded large core. If it is absent, the block tells the core to run the code itself.

The table is written by acceleration decisions from the bottleneck-waiting tracker. A decision that a bottleneck has crossed the waiting threshold installs or refreshes its mapping. A decision that it has dropped below the threshold removes the mapping. Once a remote request is issued, the core has one call outstanding. Further calls are held off until the large core's return event arrives. That event is turned into a resume pulse for the caller.

Top module: `bneck_dispatch`

## Requirements
- R1: After reset the table is empty, no call is outstanding, `call_ready` is 1, and `loc_go`, `req_valid`, `resume` and `busy` are 0.
- R2: An accepted call (`call_valid` and `call_ready` high at a clock edge) whose identifier is not in the table raises `loc_go` for exactly one cycle after that edge, and `req_valid` stays 0.
- R3: An accepted call whose identifier is in the table raises `req_valid` for exactly one cycle after that edge. `req_bid`, `req_pc` and `req_sp` carry the call's identifier, PC and stack pointer, `req_core` carries the parameter `SELF_CORE`, and `req_large` carries the large-core number stored for that identifier.
- R4: From the edge that issues a remote request until a return event is taken, `busy` is 1 and `call_ready` is 0. A call presented in that window is not accepted and produces neither `loc_go` nor `req_valid`.
- R5: A `ret_valid` pulse while `busy` is 1 clears `busy` and raises `resume` for one cycle after that edge. A `ret_valid` pulse while `busy` is 0 has no effect, and `resume` stays 0.
- R6: An install (`upd_valid`=1, `upd_accel`=1) for an identifier already in the table replaces its stored large-core number and takes no new entry.
- R7: A removal (`upd_valid`=1, `upd_accel`=0) drops the matching entry, so later calls with that identifier run locally. A removal for an identifier that is not present changes nothing.
- R8: An install of a new identifier takes the lowest-numbered empty entry. When all `ENTRIES` entries are in use, it overwrites the entry named by a replacement pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, after each such overwrite. Empty entries fill in index order 0, 1, 2, ...
- R9: When an install and a call with the same identifier meet at one clock edge, the call is decided on the table contents from before the install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_valid | input | 1 | Core presents a bottleneck call |
| call_id | input | ID_W | Bottleneck identifier of the call |
| call_pc | input | ADDR_W | Target PC of the bottleneck code |
| call_sp | input | ADDR_W | Caller stack pointer |
| call_ready | output | 1 | Block can accept a call (no remote call outstanding) |
| ret_valid | input | 1 | Return event from the large core |
| upd_valid | input | 1 | Acceleration decision present |
| upd_accel | input | 1 | 1 = install/refresh mapping, 0 = remove mapping |
| upd_id | input | ID_W | Identifier the decision applies to |
| upd_large | input | LC_W | Large core chosen for the identifier |
| loc_go | output | 1 | One-cycle pulse: run the call locally |
| req_valid | output | 1 | One-cycle pulse: remote request issued |
| req_bid | output | ID_W | Request identifier |
| req_pc | output | ADDR_W | Request target PC |
| req_sp | output | ADDR_W | Request stack pointer |
| req_core | output | CORE_W | Number of the calling small core |
| req_large | output | LC_W | Destination large core |
| resume | output | 1 | One-cycle pulse: remote call finished, caller continues |
| busy | output | 1 | A remote call is outstanding |

## Verification
The hardest state to reach from the ports is a full table whose replacement pointer has moved. The bench resets and then installs 32 distinct identifiers, which fills entries 0 to 31 in order. It then installs two further identifiers and probes with calls. The first two original identifiers must now run locally, their neighbours must still go remote, and the newcomers must go remote. The same-edge case of an install and a call is driven on one falling edge, so the call must observe the old table.

// File: rtl/bdt_pkg.sv
// Package: shared defaults and the write-selection encoding used by the
// dispatch table storage. Assumes nothing beyond 1800-2017 packages.
package bdt_pkg;
    localparam int unsigned DEF_ENTRIES = 32;
    localparam int unsigned DEF_ID_W    = 16;
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_LC_W    = 2;
    localparam int unsigned DEF_CORE_W  = 6;

    // How an install decision picks its destination entry
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_MATCH = 2'd1,
        WR_FREE  = 2'd2,
        WR_EVICT = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/bdt_table.sv
// Module: associative identifier-to-large-core store.
// Does: combinational lookup for calls; install/refresh/remove on updates;
// fills the lowest free entry, otherwise evicts round-robin.
// Assumes: at most one valid entry per identifier (guaranteed by refresh
// on match); lookup sees contents before any same-edge update.
module bdt_table
    import bdt_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned ID_W    = DEF_ID_W,
    parameter int unsigned LC_W    = DEF_LC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] lk_id,
    output logic            lk_hit,
    output logic [LC_W-1:0] lk_large,
    input  logic            up_valid,
    input  logic            up_install,
    input  logic [ID_W-1:0] up_id,
    input  logic [LC_W-1:0] up_large
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]  ent_vld;
    logic [ID_W-1:0]     ent_id    [ENTRIES];
    logic [LC_W-1:0]     ent_large [ENTRIES];
    logic [ENTRIES-1:0]  lk_match;
    logic [ENTRIES-1:0]  up_match;
    logic [ENTRIES-1:0]  wr_en;
    logic [ENTRIES-1:0]  clr_en;
    logic [IDX_W-1:0]    free_idx;
    logic                free_any;
    logic [IDX_W-1:0]    rr_ptr;
    wr_sel_e             wr_sel;

    // Per-entry comparators for lookup and update
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign lk_match[g] = ent_vld[g] && (ent_id[g] == lk_id);
            assign up_match[g] = ent_vld[g] && (ent_id[g] == up_id);
        end
    endgenerate

    // Lookup result: hit flag and the stored large core of the match
    always_comb begin
        lk_hit   = |lk_match;
        lk_large = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_large = lk_large | (ent_large[i] & {LC_W{lk_match[i]}});
        end
    end

    // Lowest-indexed empty entry
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    // Choose the destination kind for an install
    always_comb begin
        if (!(up_valid && up_install)) wr_sel = WR_NONE;
        else if (|up_match)            wr_sel = WR_MATCH;
        else if (free_any)             wr_sel = WR_FREE;
        else                           wr_sel = WR_EVICT;
    end

    // Per-entry write and clear enables
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_en
            always_comb begin
                case (wr_sel)
                    WR_MATCH: wr_en[g] = up_match[g];
                    WR_FREE:  wr_en[g] = (free_idx == IDX_W'(g));
                    WR_EVICT: wr_en[g] = (rr_ptr == IDX_W'(g));
                    default:  wr_en[g] = 1'b0;
                endcase
                clr_en[g] = up_valid && !up_install && up_match[g];
            end
        end
    endgenerate

    // Entry storage
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_vld[g]   <= 1'b0;
                    ent_id[g]    <= '0;
                    ent_large[g] <= '0;
                end else if (wr_en[g]) begin
                    ent_vld[g]   <= 1'b1;
                    ent_id[g]    <= up_id;
                    ent_large[g] <= up_large;
                end else if (clr_en[g]) begin
                    ent_vld[g]   <= 1'b0;
                end
            end
        end
    endgenerate

    // Replacement pointer: advances only on an eviction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (wr_sel == WR_EVICT) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/bdt_dispatch.sv
// Module: call steering and outstanding-call tracker.
// Does: accepts a call when idle, pulses local or forms a remote request
// one cycle later, holds busy until the return event, pulses resume.
// Assumes: hit/large come combinationally from the table for call_id.
module bdt_dispatch
    import bdt_pkg::*;
#(
    parameter int unsigned ID_W      = DEF_ID_W,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned LC_W      = DEF_LC_W,
    parameter int unsigned CORE_W    = DEF_CORE_W,
    parameter int unsigned SELF_CORE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_valid,
    input  logic [ID_W-1:0]   call_id,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] call_sp,
    output logic              call_ready,
    input  logic              tbl_hit,
    input  logic [LC_W-1:0]   tbl_large,
    input  logic              ret_valid,
    output logic              loc_go,
    output logic              req_valid,
    output logic [ID_W-1:0]   req_bid,
    output logic [ADDR_W-1:0] req_pc,
    output logic [ADDR_W-1:0] req_sp,
    output logic [CORE_W-1:0] req_core,
    output logic [LC_W-1:0]   req_large,
    output logic              resume,
    output logic              busy
);
    logic accept;

    // Calls are taken only with no remote call in flight
    assign call_ready = !busy;
    assign accept     = call_valid && call_ready;
    assign req_core   = CORE_W'(SELF_CORE);

    // Decision pulses and outstanding-call state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_go    <= 1'b0;
            req_valid <= 1'b0;
            resume    <= 1'b0;
            busy      <= 1'b0;
        end else begin
            loc_go    <= accept && !tbl_hit;
            req_valid <= accept && tbl_hit;
            resume    <= ret_valid && busy;
            if (accept && tbl_hit) busy <= 1'b1;
            else if (ret_valid)    busy <= 1'b0;
        end
    end

    // Remote request payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_bid   <= '0;
            req_pc    <= '0;
            req_sp    <= '0;
            req_large <= '0;
        end else if (accept && tbl_hit) begin
            req_bid   <= call_id;
            req_pc    <= call_pc;
            req_sp    <= call_sp;
            req_large <= tbl_large;
        end
    end
endmodule

// File: rtl/bneck_dispatch.sv
// Module: top of the per-core bottleneck dispatch table.
// Does: joins the identifier store with the call steering logic.
// Assumes: updates arrive as single-cycle decisions; one outstanding
// remote call per core.
module bneck_dispatch
    import bdt_pkg::*;
#(
    parameter int unsigned ENTRIES   = DEF_ENTRIES,
    parameter int unsigned ID_W      = DEF_ID_W,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned LC_W      = DEF_LC_W,
    parameter int unsigned CORE_W    = DEF_CORE_W,
    parameter int unsigned SELF_CORE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_valid,
    input  logic [ID_W-1:0]   call_id,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] call_sp,
    output logic              call_ready,
    input  logic              ret_valid,
    input  logic              upd_valid,
    input  logic              upd_accel,
    input  logic [ID_W-1:0]   upd_id,
    input  logic [LC_W-1:0]   upd_large,
    output logic              loc_go,
    output logic              req_valid,
    output logic [ID_W-1:0]   req_bid,
    output logic [ADDR_W-1:0] req_pc,
    output logic [ADDR_W-1:0] req_sp,
    output logic [CORE_W-1:0] req_core,
    output logic [LC_W-1:0]   req_large,
    output logic              resume,
    output logic              busy
);
    logic            tbl_hit;
    logic [LC_W-1:0] tbl_large;

    bdt_table #(.ENTRIES(ENTRIES), .ID_W(ID_W), .LC_W(LC_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .lk_id(call_id), .lk_hit(tbl_hit), .lk_large(tbl_large),
        .up_valid(upd_valid), .up_install(upd_accel),
        .up_id(upd_id), .up_large(upd_large)
    );

    bdt_dispatch #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LC_W(LC_W),
                   .CORE_W(CORE_W), .SELF_CORE(SELF_CORE)) u_dsp (
        .clk(clk), .rst_n(rst_n),
        .call_valid(call_valid), .call_id(call_id),
        .call_pc(call_pc), .call_sp(call_sp), .call_ready(call_ready),
        .tbl_hit(tbl_hit), .tbl_large(tbl_large), .ret_valid(ret_valid),
        .loc_go(loc_go), .req_valid(req_valid), .req_bid(req_bid),
        .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
        .req_large(req_large), .resume(resume), .busy(busy)
    );
endmodule

// File: rtl/bneck_dispatch_chk.sv
// Checker: temporal properties at the top-level ports.
module bneck_dispatch_chk #(
    parameter int unsigned ID_W   = 16,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_valid,
    input logic              call_ready,
    input logic [ID_W-1:0]   call_id,
    input logic [ADDR_W-1:0] call_pc,
    input logic              ret_valid,
    input logic              busy,
    input logic              loc_go,
    input logic              req_valid,
    input logic [ID_W-1:0]   req_bid,
    input logic [ADDR_W-1:0] req_pc,
    input logic              resume
);
    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_go && req_valid));

    // R2
    accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && call_ready) |=> (loc_go || req_valid));

    // R3
    req_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && call_ready) |=>
            (!req_valid || (req_bid == $past(call_id) && req_pc == $past(call_pc))));

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !call_ready) |=> (!loc_go && !req_valid));

    // R4
    issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (busy && !call_ready));

    // R5
    ret_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && busy) |=> (resume && !busy));

    // R5
    ret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !busy) |=> !resume);
endmodule

bind bneck_dispatch bneck_dispatch_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_ready(call_ready),
    .call_id(call_id), .call_pc(call_pc), .ret_valid(ret_valid), .busy(busy),
    .loc_go(loc_go), .req_valid(req_valid), .req_bid(req_bid),
    .req_pc(req_pc), .resume(resume)
);

// File: tb/sim_bneck_dispatch.sv
`timescale 1ns/1ps
module sim_bneck_dispatch;
    localparam int ID_W = 16, ADDR_W = 32, LC_W = 2, CORE_W = 6, SELF = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              call_valid = 1'b0;
    logic [ID_W-1:0]   call_id = '0;
    logic [ADDR_W-1:0] call_pc = '0;
    logic [ADDR_W-1:0] call_sp = '0;
    logic              call_ready;
    logic              ret_valid = 1'b0;
    logic              upd_valid = 1'b0;
    logic              upd_accel = 1'b0;
    logic [ID_W-1:0]   upd_id = '0;
    logic [LC_W-1:0]   upd_large = '0;
    logic              loc_go, req_valid, resume, busy;
    logic [ID_W-1:0]   req_bid;
    logic [ADDR_W-1:0] req_pc, req_sp;
    logic [CORE_W-1:0] req_core;
    logic [LC_W-1:0]   req_large;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bneck_dispatch #(.SELF_CORE(SELF)) u0 (.*);

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic upd(bit accel, int id, int lc);
        @(negedge clk);
        upd_valid = 1'b1; upd_accel = accel;
        upd_id = ID_W'(id); upd_large = LC_W'(lc);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Present one call for one edge; check outcome one cycle later
    task automatic call(string tag, int id, bit exp_remote, int exp_lc);
        @(negedge clk);
        call_valid = 1'b1; call_id = ID_W'(id);
        call_pc = 32'h1000_0000 + id; call_sp = 32'h7fff_0000 - id;
        @(negedge clk);
        call_valid = 1'b0;
        chk({tag, " loc_go"}, loc_go, !exp_remote);
        chk({tag, " req_valid"}, req_valid, exp_remote);
        if (exp_remote) begin
            chk({tag, " req_bid"}, req_bid, id);
            chk({tag, " req_pc"}, req_pc, 32'h1000_0000 + id);
            chk({tag, " req_sp"}, req_sp, 32'h7fff_0000 - id);
            chk({tag, " req_core"}, req_core, SELF);
            chk({tag, " req_large"}, req_large, exp_lc);
        end
    endtask

    task automatic ret(string tag, bit exp_resume);
        @(negedge clk); ret_valid = 1'b1;
        @(negedge clk); ret_valid = 1'b0;
        chk({tag, " resume"}, resume, exp_resume);
        chk({tag, " busy"}, busy, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 call_ready", call_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 loc_go", loc_go, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 resume", resume, 0);
        call("R1 empty table", 7, 0, 0);
    endtask

    task automatic t_miss();
        call("R2 miss", 16'h33, 0, 0);
        @(negedge clk);
        chk("R2 pulse width", loc_go, 0);
    endtask

    task automatic t_hit_stall_return();
        upd(1, 16'h40, 2);
        call("R3 hit", 16'h40, 1, 2);
        chk("R4 busy", busy, 1);
        chk("R4 call_ready", call_ready, 0);
        @(negedge clk);
        chk("R3 pulse width", req_valid, 0);
        // R4: call presented while outstanding is not taken
        call_valid = 1'b1; call_id = 16'h33;
        @(negedge clk);
        @(negedge clk);
        call_valid = 1'b0;
        chk("R4 stalled loc_go", loc_go, 0);
        chk("R4 stalled req", req_valid, 0);
        ret("R5 return", 1);
        chk("R5 call_ready", call_ready, 1);
        ret("R5 idle return", 0);
    endtask

    task automatic t_overwrite();
        upd(1, 16'h40, 3);
        call("R6 refresh", 16'h40, 1, 3);
        ret("R6 ret", 1);
    endtask

    task automatic t_remove();
        upd(1, 16'h41, 1);
        upd(0, 16'h40, 0);
        call("R7 removed", 16'h40, 0, 0);
        upd(0, 16'h99, 0);
        call("R7 absent removal", 16'h41, 1, 1);
        ret("R7 ret", 1);
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        upd_valid = 1'b1; upd_accel = 1'b1; upd_id = 16'h55; upd_large = 2'd1;
        call_valid = 1'b1; call_id = 16'h55;
        call_pc = 32'h1000_0055; call_sp = 32'h7fff_0000 - 32'h55;
        @(negedge clk);
        upd_valid = 1'b0; call_valid = 1'b0;
        chk("R9 old contents loc_go", loc_go, 1);
        chk("R9 old contents req", req_valid, 0);
        call("R9 after install", 16'h55, 1, 1);
        ret("R9 ret", 1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 32; i++) upd(1, 100 + i, i % 4);
        call("R8 full hit", 131, 1, 3);
        ret("R8 ret a", 1);
        upd(1, 200, 2);
        upd(1, 201, 1);
        call("R8 evicted entry0", 100, 0, 0);
        call("R8 evicted entry1", 101, 0, 0);
        call("R8 kept entry2", 102, 1, 2);
        ret("R8 ret b", 1);
        call("R8 new id", 200, 1, 2);
        ret("R8 ret c", 1);
        // R8: a freed slot is used before the pointer entry
        upd(0, 110, 0);
        upd(1, 300, 3);
        call("R8 free reuse", 102, 1, 2);
        ret("R8 ret d", 1);
        call("R8 free reuse new", 300, 1, 3);
        ret("R8 ret e", 1);
    endtask

    initial begin
        t_reset();
        t_miss();
        t_hit_stall_return();
        t_overwrite();
        t_remove();
        t_same_edge();
        t_full();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule